// File: doc/BRIEF.md
# Dual-Context Interrupt Controller

This block collects up to 32 interrupt lines and presents them to two independent execution contexts. Each line is conditioned, then captured into one shared status register. Most lines are level-sensitive and copy the conditioned input into status on every clock. A fixed group of lines is edge-sensitive and holds a captured rising transition until software clears it by writing a one. Three external lines (sources 4, 5 and 6) have a programmable polarity and a programmable trigger mode.

Each context owns a 32-bit enable mask. The controller ANDs the status register with that mask to form the context's pending set. From the pending set it drives a registered interrupt line and a registered 5-bit source number. The source number is picked by a fixed order: the timer of context 0 first, then the timer of context 1, then the cascade line from a secondary controller, then the lowest-numbered pending source. The interrupt line also serves as the valid flag for the source number.

Software reaches four word-addressed registers through a single-cycle synchronous bus. Read data is registered.

Top module: `dual_ctx_intc`

## Requirements
- R1: After reset both masks, the status register, the external configuration register and the read data are zero, and both context interrupt lines are low.
- R2: A level-sensitive source copies its conditioned input into its status bit on every clock. Writing a one to that bit has no lasting effect while the input stays active.
- R3: Sources 14, 15, 16 and 18 are always edge-sensitive. Sources 0 to 3 are edge-sensitive when the low-edge parameter is 1, which is the default. On such a source, a clock where the conditioned input goes from inactive to active sets the status bit, and the bit stays set after the input falls.
- R4: A write to word 2 clears every status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R5: If a new edge on an edge-sensitive source arrives in the same clock as a write-one-to-clear of that bit, the bit stays set.
- R6: Bits 4 to 6 of the external configuration register (word 3) set the polarity of sources 4 to 6. A 1 makes the input active high and a 0 makes it active low. The reset value is active low.
- R7: Bits 12 to 14 of word 3 set the trigger mode of sources 4 to 6, in that order. A 0 selects level and a 1 selects edge. Only bits 4 to 6 and 12 to 14 of word 3 are stored; all other bits read back as 0.
- R8: Word 0 is the mask of context 0 and word 1 is the mask of context 1, where a 1 enables the source. A context's interrupt line rises one clock after its masked status becomes non-zero. A source enabled in only one context never raises the other context's line.
- R9: The source number of a context is 21 if source 21 is pending, else 22 if source 22 is pending, else 27 if source 27 is pending, else the lowest pending source.
- R10: When a context has no pending source, its interrupt line is low and its source number is 0.
- R11: A read presented with the bus enable high and the write enable low returns the addressed register on the read data one clock later. A read in the clock after a write returns the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 mask ctx0, 1 mask ctx1, 2 status, 3 external config |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 32 | Raw interrupt lines, bit n is source n |
| ctx0_irq | output | 1 | Context 0 interrupt, also the valid flag of ctx0_vec |
| ctx0_vec | output | 5 | Selected source number for context 0 |
| ctx1_irq | output | 1 | Context 1 interrupt, also the valid flag of ctx1_vec |
| ctx1_vec | output | 5 | Selected source number for context 1 |

## Verification
A wrong status bit appears on the context outputs two clocks after the input change that caused it. It also appears on the read data one clock after a status read. A stale previous-input register would create or hide an edge in the same clock. A mask or priority fault would show as a wrong line or source number one clock after the masked status changes. The bench compares every output with a behavioural model on every clock, so such a fault is reported within a few cycles of its cause. The directed stimulus drives the priority order, edge and clear collisions, and polarity and mode changes.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    RA_MASK0 = 2'd0,
    RA_MASK1 = 2'd1,
    RA_STAT  = 2'd2,
    RA_XCFG  = 2'd3
  } reg_addr_e;

  localparam int XSRC_LO  = 4;   // first external source with polarity/mode
  localparam int XCNT     = 3;   // number of configurable external sources
  localparam int XMODE_LO = 12;  // first trigger-mode bit in the config word
  localparam int NCTX     = 2;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [N_SRC-1:0] bus_wdata,
  input  logic [N_SRC-1:0] stat_q,
  output logic [N_SRC-1:0] mask0_q,
  output logic [N_SRC-1:0] mask1_q,
  output logic [N_SRC-1:0] xcfg_q,
  output logic [N_SRC-1:0] clr_vec,
  output logic [N_SRC-1:0] bus_rdata
);
  localparam logic [N_SRC-1:0] POL_BITS  = N_SRC'(((1 << XCNT) - 1) << XSRC_LO);
  localparam logic [N_SRC-1:0] MODE_BITS = N_SRC'(((1 << XCNT) - 1) << XMODE_LO);
  localparam logic [N_SRC-1:0] XCFG_KEEP = POL_BITS | MODE_BITS;

  reg_addr_e ra;
  logic      wr, rd;

  assign ra      = reg_addr_e'(bus_addr);
  assign wr      = bus_en && bus_we;
  assign rd      = bus_en && !bus_we;
  assign clr_vec = (wr && ra == RA_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask0_q   <= '0;
      mask1_q   <= '0;
      xcfg_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr) begin
        case (ra)
          RA_MASK0: mask0_q <= bus_wdata;
          RA_MASK1: mask1_q <= bus_wdata;
          RA_XCFG:  xcfg_q  <= bus_wdata & XCFG_KEEP;
          default:  ;
        endcase
      end
      if (rd) begin
        case (ra)
          RA_MASK0: bus_rdata <= mask0_q;
          RA_MASK1: bus_rdata <= mask1_q;
          RA_STAT:  bus_rdata <= stat_q;
          default:  bus_rdata <= xcfg_q;
        endcase
      end
    end
  end

  // R1: masks come out of reset disabled
  p_mask_clear_r1: assert property (@(posedge clk)
    rst |=> (mask0_q == '0 && mask1_q == '0 && xcfg_q == '0));

  // R11: a read of word 0 returns the mask seen when it was presented
  p_rd_latency_r11: assert property (@(posedge clk) disable iff (rst)
    (!rst && rd && ra == RA_MASK0) |=> (bus_rdata == $past(mask0_q)));

  // R7: unused configuration bits never hold a one
  p_xcfg_unused_r7: assert property (@(posedge clk) disable iff (rst)
    (xcfg_q & ~XCFG_KEEP) == '0);
endmodule

// File: rtl/intc_capture.sv
module intc_capture
  import intc_pkg::*;
#(
  parameter int               N_SRC       = 32,
  parameter logic [N_SRC-1:0] EDGE_FIX    = 32'h0005_C000,
  parameter bit               LOW_EDGE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] xcfg_q,
  input  logic [N_SRC-1:0] clr_vec,
  output logic [N_SRC-1:0] stat_q
);
  localparam logic [N_SRC-1:0] LOW_EDGES = LOW_EDGE_EN ? N_SRC'(4'hF) : '0;
  localparam logic [N_SRC-1:0] BASE_EDGE = EDGE_FIX | LOW_EDGES;

  logic [N_SRC-1:0] act, edge_m, prev_q, evt, stat_d;

  always_comb begin
    act    = irq_in;
    edge_m = BASE_EDGE;
    for (int k = 0; k < XCNT; k++) begin
      if (!xcfg_q[XSRC_LO+k]) act[XSRC_LO+k] = ~irq_in[XSRC_LO+k];
      edge_m[XSRC_LO+k] = xcfg_q[XMODE_LO+k];
    end
    evt    = act & ~prev_q & edge_m;
    stat_d = (edge_m & ((stat_q & ~clr_vec) | evt)) | (~edge_m & act);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= act;
      stat_q <= stat_d;
    end
  end

  // R3: a set fixed-edge bit that is not cleared stays set
  p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((stat_q & $past(stat_q & ~clr_vec & EDGE_FIX))
              == $past(stat_q & ~clr_vec & EDGE_FIX)));

  // R5: a fresh edge on a fixed-edge source always lands in status
  p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((stat_q & $past(act & ~prev_q & EDGE_FIX))
              == $past(act & ~prev_q & EDGE_FIX)));

  // R2: level sources follow the conditioned input
  p_level_mirror_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((stat_q & $past(~edge_m)) == $past(act & ~edge_m)));
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N_SRC    = 32,
  parameter int VEC_W    = 5,
  parameter int TMR0_BIT = 21,
  parameter int TMR1_BIT = 22,
  parameter int CASC_BIT = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] stat_q,
  input  logic [N_SRC-1:0] mask_q,
  output logic             irq_q,
  output logic [VEC_W-1:0] vec_q
);
  logic [N_SRC-1:0] pend;
  logic [VEC_W-1:0] low, sel;

  always_comb begin
    pend = stat_q & mask_q;
    low  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) low = VEC_W'(i);
    end
    if (pend[TMR0_BIT])      sel = VEC_W'(TMR0_BIT);
    else if (pend[TMR1_BIT]) sel = VEC_W'(TMR1_BIT);
    else if (pend[CASC_BIT]) sel = VEC_W'(CASC_BIT);
    else                     sel = low;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= |pend;
      vec_q <= (|pend) ? sel : '0;
    end
  end

  // R8: interrupt line follows the masked status one clock later
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_q == (|$past(stat_q & mask_q))));

  // R9: the context-0 timer always wins
  p_tmr0_first_r9: assert property (@(posedge clk) disable iff (rst)
    (!rst && pend[TMR0_BIT]) |=> (vec_q == VEC_W'(TMR0_BIT)));

  // R9: a reported source was really pending
  p_vec_live_r9: assert property (@(posedge clk) disable iff (rst)
    (!rst && (|pend)) |=> ((($past(pend) >> vec_q) & N_SRC'(1)) != '0));

  // R10: idle context reports source 0
  p_vec_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !irq_q |-> (vec_q == '0));
endmodule

// File: rtl/dual_ctx_intc.sv
module dual_ctx_intc
  import intc_pkg::*;
#(
  parameter int               N_SRC       = 32,
  parameter int               TMR0_BIT    = 21,
  parameter int               TMR1_BIT    = 22,
  parameter int               CASC_BIT    = 27,
  parameter logic [N_SRC-1:0] EDGE_FIX    = 32'h0005_C000,
  parameter bit               LOW_EDGE_EN = 1'b1,
  parameter int               VEC_W       = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [N_SRC-1:0] bus_wdata,
  output logic [N_SRC-1:0] bus_rdata,
  input  logic [N_SRC-1:0] irq_in,
  output logic             ctx0_irq,
  output logic [VEC_W-1:0] ctx0_vec,
  output logic             ctx1_irq,
  output logic [VEC_W-1:0] ctx1_vec
);
  logic [N_SRC-1:0] stat_q, xcfg_q, clr_vec;
  logic [N_SRC-1:0] mask_a [NCTX];
  logic             irq_a  [NCTX];
  logic [VEC_W-1:0] vec_a  [NCTX];

  intc_regs #(.N_SRC(N_SRC)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .stat_q   (stat_q),
    .mask0_q  (mask_a[0]),
    .mask1_q  (mask_a[1]),
    .xcfg_q   (xcfg_q),
    .clr_vec  (clr_vec),
    .bus_rdata(bus_rdata)
  );

  intc_capture #(
    .N_SRC      (N_SRC),
    .EDGE_FIX   (EDGE_FIX),
    .LOW_EDGE_EN(LOW_EDGE_EN)
  ) u_cap (
    .clk    (clk),
    .rst    (rst),
    .irq_in (irq_in),
    .xcfg_q (xcfg_q),
    .clr_vec(clr_vec),
    .stat_q (stat_q)
  );

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    intc_prio #(
      .N_SRC   (N_SRC),
      .VEC_W   (VEC_W),
      .TMR0_BIT(TMR0_BIT),
      .TMR1_BIT(TMR1_BIT),
      .CASC_BIT(CASC_BIT)
    ) u_prio (
      .clk   (clk),
      .rst   (rst),
      .stat_q(stat_q),
      .mask_q(mask_a[c]),
      .irq_q (irq_a[c]),
      .vec_q (vec_a[c])
    );
  end

  assign ctx0_irq = irq_a[0];
  assign ctx0_vec = vec_a[0];
  assign ctx1_irq = irq_a[1];
  assign ctx1_vec = vec_a[1];
endmodule

// File: tb/tb_dual_ctx_intc.sv
module tb_dual_ctx_intc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = 32'h0000_0070;
  logic        ctx0_irq, ctx1_irq;
  logic [4:0]  ctx0_vec, ctx1_vec;

  int checks = 0, errors = 0, cyc = 0;
  string phase = "R1";

  always #2 clk = ~clk;  // 250 MHz

  dual_ctx_intc dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .ctx0_irq(ctx0_irq), .ctx0_vec(ctx0_vec),
    .ctx1_irq(ctx1_irq), .ctx1_vec(ctx1_vec)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_mask [2];
  bit [31:0] m_cfg, m_stat, m_prev, m_rd;
  bit        m_irq  [2];
  int        m_vec  [2];
  bit        live = 0;

  function automatic int pick(bit [31:0] p);
    if (p[21]) return 21;
    if (p[22]) return 22;
    if (p[27]) return 27;
    for (int i = 0; i < 32; i++) if (p[i]) return i;
    return 0;
  endfunction

  function automatic bit is_edge(int i, bit [31:0] cfg);
    if (i == 14 || i == 15 || i == 16 || i == 18 || i < 4) return 1;
    if (i >= 4 && i <= 6) return cfg[i + 8];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mask[0] = 0; m_mask[1] = 0; m_cfg = 0; m_stat = 0; m_prev = 0; m_rd = 0;
      m_irq[0] = 0; m_irq[1] = 0; m_vec[0] = 0; m_vec[1] = 0;
      live = 1;
    end else begin
      bit [31:0] act, ns, clr;
      for (int c = 0; c < 2; c++) begin
        m_irq[c] = ((m_stat & m_mask[c]) != 0);
        m_vec[c] = m_irq[c] ? pick(m_stat & m_mask[c]) : 0;
      end
      if (bus_en && !bus_we) begin
        case (bus_addr)
          2'd0: m_rd = m_mask[0];
          2'd1: m_rd = m_mask[1];
          2'd2: m_rd = m_stat;
          default: m_rd = m_cfg;
        endcase
      end
      act = irq_in;
      for (int k = 4; k <= 6; k++) if (!m_cfg[k]) act[k] = ~irq_in[k];
      clr = (bus_en && bus_we && bus_addr == 2'd2) ? bus_wdata : 0;
      for (int i = 0; i < 32; i++) begin
        if (is_edge(i, m_cfg)) ns[i] = (m_stat[i] && !clr[i]) || (act[i] && !m_prev[i]);
        else                   ns[i] = act[i];
      end
      if (bus_en && bus_we) begin
        if (bus_addr == 2'd0) m_mask[0] = bus_wdata;
        if (bus_addr == 2'd1) m_mask[1] = bus_wdata;
        if (bus_addr == 2'd3) m_cfg = bus_wdata & 32'h0000_7070;
      end
      m_prev = act;
      m_stat = ns;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] act_v, logic [31:0] exp_v, string what);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (t=%0t)", tag, what, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk(phase, 32'(ctx0_irq), 32'(m_irq[0]), "model ctx0_irq");
      chk(phase, 32'(ctx1_irq), 32'(m_irq[1]), "model ctx1_irq");
      chk(phase, 32'(ctx0_vec), 32'(m_vec[0]), "model ctx0_vec");
      chk(phase, 32'(ctx1_vec), 32'(m_vec[1]), "model ctx1_vec");
      chk(phase, bus_rdata, m_rd, "model bus_rdata");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0;
    chk(tag, bus_rdata, e, "read-back");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int b);
    @(negedge clk); irq_in[b] = 1'b1;
    @(negedge clk); irq_in[b] = 1'b0;
  endtask

  initial begin
    idle(4);
    rst = 0;
    idle(1);
    // R1: reset state
    chk("R1", 32'(ctx0_irq), 0, "ctx0_irq after reset");
    chk("R1", bus_rdata, 0, "rdata after reset");
    rd_chk(2'd0, 32'h0, "R1");
    rd_chk(2'd2, 32'h0, "R1");

    // R11: register map and read latency
    phase = "R11";
    wr(2'd0, 32'hFFFF_FFFF);
    rd_chk(2'd0, 32'hFFFF_FFFF, "R11");
    wr(2'd1, 32'h0840_0100);
    rd_chk(2'd1, 32'h0840_0100, "R11");
    // R7: only polarity and mode bits are stored
    phase = "R7";
    wr(2'd3, 32'hFFFF_FFFF);
    rd_chk(2'd3, 32'h0000_7070, "R7");
    irq_in = 32'h0;
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'h0000_0070);
    wr(2'd2, 32'hFFFF_FFFF);
    rd_chk(2'd2, 32'h0, "R4");

    // R2: level source mirrors input, clear has no lasting effect
    phase = "R2";
    @(negedge clk); irq_in[8] = 1'b1;
    idle(2);
    chk("R2", 32'(ctx0_vec), 8, "ctx0_vec level source");
    chk("R8", 32'(ctx1_irq), 1, "ctx1_irq source enabled in both");
    wr(2'd2, 32'h0000_0100);
    rd_chk(2'd2, 32'h0000_0100, "R2");
    @(negedge clk); irq_in[8] = 1'b0;
    idle(2);
    chk("R10", 32'(ctx0_irq), 0, "ctx0_irq idle");
    chk("R10", 32'(ctx0_vec), 0, "ctx0_vec idle");

    // R3: edge capture holds after the input falls
    phase = "R3";
    pulse(15);
    idle(2);
    rd_chk(2'd2, 32'h0000_8000, "R3");
    chk("R3", 32'(ctx0_vec), 15, "ctx0_vec edge source");
    chk("R8", 32'(ctx1_irq), 0, "ctx1_irq source masked");

    // R4: write-one-to-clear
    phase = "R4";
    wr(2'd2, 32'h0);
    rd_chk(2'd2, 32'h0000_8000, "R4");
    wr(2'd2, 32'h0000_8000);
    rd_chk(2'd2, 32'h0, "R4");

    // R5: new edge beats a same-cycle clear
    phase = "R5";
    @(negedge clk); irq_in[16] = 1'b1;
    idle(2);
    irq_in[16] = 1'b0;
    idle(1);
    irq_in[16] = 1'b1;
    bus_en = 1; bus_we = 1; bus_addr = 2'd2; bus_wdata = 32'h0001_0000;
    @(negedge clk); bus_en = 0; bus_we = 0;
    rd_chk(2'd2, 32'h0001_0000, "R5");
    wr(2'd2, 32'h0001_0000);
    rd_chk(2'd2, 32'h0, "R5");
    @(negedge clk); irq_in[16] = 1'b0;

    // R6: polarity of an external source
    phase = "R6";
    wr(2'd3, 32'h0000_0060);
    idle(2);
    rd_chk(2'd2, 32'h0000_0010, "R6");
    chk("R6", 32'(ctx0_vec), 4, "ctx0_vec active-low source");
    wr(2'd3, 32'h0000_0070);
    idle(1);
    rd_chk(2'd2, 32'h0, "R6");

    // R7: edge mode on an external source
    phase = "R7";
    wr(2'd3, 32'h0000_1070);
    rd_chk(2'd2, 32'h0, "R7");
    pulse(4);
    idle(2);
    rd_chk(2'd2, 32'h0000_0010, "R7");
    wr(2'd2, 32'h0000_0010);
    rd_chk(2'd2, 32'h0, "R7");
    wr(2'd3, 32'h0000_0070);

    // R9: fixed priority then lowest bit
    phase = "R9";
    @(negedge clk); irq_in = 32'h0860_0100;
    idle(2);
    chk("R9", 32'(ctx0_vec), 21, "ctx0 timer0 first");
    chk("R9", 32'(ctx1_vec), 22, "ctx1 timer1 (timer0 masked)");
    irq_in[21] = 1'b0; idle(2);
    chk("R9", 32'(ctx0_vec), 22, "ctx0 timer1 second");
    irq_in[22] = 1'b0; idle(2);
    chk("R9", 32'(ctx0_vec), 27, "ctx0 cascade third");
    chk("R9", 32'(ctx1_vec), 27, "ctx1 cascade third");
    irq_in[27] = 1'b0; idle(2);
    chk("R9", 32'(ctx1_vec), 8, "ctx1 lowest remaining");
    pulse(2);
    idle(1);
    chk("R9", 32'(ctx0_vec), 2, "ctx0 lowest edge source");
    chk("R9", 32'(ctx1_vec), 8, "ctx1 ignores masked low source");
    @(negedge clk); irq_in = 32'h0;
    wr(2'd2, 32'hFFFF_FFFF);
    idle(2);
    phase = "R10";
    chk("R10", 32'(ctx0_irq), 0, "ctx0 idle after clear");
    chk("R10", 32'(ctx1_vec), 0, "ctx1 vec idle after clear");

    // R8: per-context masks are independent
    phase = "R8";
    wr(2'd0, 32'h0);
    @(negedge clk); irq_in[8] = 1'b1;
    idle(2);
    chk("R8", 32'(ctx0_irq), 0, "ctx0 masked off");
    chk("R8", 32'(ctx1_irq), 1, "ctx1 still enabled");
    chk("R8", 32'(ctx1_vec), 8, "ctx1 vec");
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule